// File: doc/BRIEF.md
# Bus Cycle Cacheability Indicator

This block drives the active-low cacheability mark that accompanies every bus cycle of a write-back-capable processor bus. In the address-strobe cycle the mark is computed combinationally from the cycle kind and the page cacheability attribute. It is then held in a register through any wait states and dropped after the first ready strobe of the cycle. Whenever the bus is surrendered, through hold acknowledge or back-off, the pin stops being driven: `cache_oe` falls and the pad logic floats the pin. The cycle in progress is abandoned, and the restarted cycle's address strobe computes the mark again.

Reads are marked only when the page allows caching. Locked reads are never marked. Writes are never marked, whatever their page attribute, because writes do not allocate. Replacement and snoop-forced write-backs are always marked. In the first-ready cycle the block combines the held mark with the external cache-enable input. It tells the bus controller whether a plain read is to be converted into a burst line fill.

The sequencer has three states. `ST_IDLE` drives the mark inactive and waits for an address strobe. `ST_HELD` drives the value captured at the strobe. `ST_FLOAT` is entered while the bus is surrendered.

The transitions are as follows:
- From `ST_IDLE` or `ST_FLOAT`, a surrender goes to `ST_FLOAT`.
- From `ST_IDLE` or `ST_FLOAT`, an address strobe with the bus owned goes to `ST_HELD`.
- From `ST_IDLE` or `ST_FLOAT`, any other cycle goes to `ST_IDLE`.
- From `ST_HELD`, a surrender goes to `ST_FLOAT`.
- From `ST_HELD`, a ready strobe goes to `ST_IDLE`.

Top module: `cache_attr_drv`

## Requirements
- R1: While reset is applied and directly after it, `cache_n` is 1, `cache_oe` is 1 and `line_fill` is 0.
- R2: In the cycle after the first `rdy_n`=0 or `brdy_n`=0 of a held cycle, `cache_n` is 1, and it stays 1 until the next address strobe.
- R3: A locked read (`cyc_kind`=1) gives `cache_n`=1 in its address-strobe cycle.
- R4: A write (`cyc_kind`=4) gives `cache_n`=1 whatever `page_cacheable` is. Codes 5 to 7 are not used and also give 1.
- R5: A replacement write-back (`cyc_kind`=2) or a snoop-forced write-back (`cyc_kind`=3) gives `cache_n`=0 whatever `page_cacheable` is.
- R6: A read (`cyc_kind`=0) gives `cache_n`=0 in the address-strobe cycle (`ads_n`=0) exactly when `page_cacheable`=1.
- R7: From the address-strobe cycle until the first ready, `cache_n` keeps the value it had in the strobe cycle, even if `cyc_kind` and `page_cacheable` change.
- R8: In every cycle with `hlda`=1 or `boff_n`=0, `cache_oe` is 0 and `line_fill` is 0.
- R9: When the bus is surrendered, the cycle in progress is dropped and an address strobe seen while surrendered is ignored. After release, `cache_n` is 1 until a new address strobe, and that strobe computes the mark afresh.
- R10: `line_fill` is 1 only in the first-ready cycle of a read (`cyc_kind`=0) whose held mark is 0, with `ken_n`=0 and the bus owned. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads_n | input | 1 | Address strobe, active low |
| cyc_kind | input | 3 | Cycle kind: 0 read, 1 locked read, 2 replacement write-back, 3 snoop write-back, 4 write |
| page_cacheable | input | 1 | Page attribute allowing caching of a read |
| rdy_n | input | 1 | Non-burst ready, active low |
| brdy_n | input | 1 | Burst ready, active low |
| hlda | input | 1 | Hold acknowledge, active high |
| boff_n | input | 1 | Back-off, active low |
| ken_n | input | 1 | External cache enable, active low |
| cache_n | output | 1 | Cacheability mark, active low |
| cache_oe | output | 1 | Pin drive enable; 0 floats the mark |
| line_fill | output | 1 | Convert the current read into a burst line fill |

## Verification
The fill decision and the mark's drop both fall on the first-ready cycle. A surrender can land in that same cycle or in the address-strobe cycle. The bench sweeps every cycle kind, page attribute, cache-enable level, ready type and a range of wait states. At the ready cycle it checks that the fill output matches the arithmetic of kind, attribute and enable, and in the next cycle it checks that the mark has dropped. Surrender is then asserted together with a ready, with cache enable low, and in an address-strobe cycle. Each case must float the pin, suppress the fill and leave the strobe uncaptured.

// File: rtl/cattr_pkg.sv
package cattr_pkg;

    parameter int CYC_W = 3;

    localparam logic [CYC_W-1:0] CYC_READ     = CYC_W'(0);
    localparam logic [CYC_W-1:0] CYC_LOCK_RD  = CYC_W'(1);
    localparam logic [CYC_W-1:0] CYC_WB_REPL  = CYC_W'(2);
    localparam logic [CYC_W-1:0] CYC_WB_SNOOP = CYC_W'(3);
    localparam logic [CYC_W-1:0] CYC_WRITE    = CYC_W'(4);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_FLOAT = 2'd2
    } phase_e;

endpackage

// File: rtl/cattr_decode.sv
module cattr_decode
    import cattr_pkg::*;
(
    input  logic [CYC_W-1:0] kind,
    input  logic             cacheable,
    output logic             mark,
    output logic             is_read
);
    always_comb begin
        mark    = 1'b0;
        is_read = 1'b0;
        unique case (kind)
            CYC_READ: begin
                mark    = cacheable;
                is_read = 1'b1;
            end
            CYC_WB_REPL, CYC_WB_SNOOP: mark = 1'b1;
            CYC_LOCK_RD: mark = 1'b0;
            default: mark = 1'b0;
        endcase
    end
endmodule

// File: rtl/cattr_seq.sv
module cattr_seq
    import cattr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ads_n,
    input  logic rdy_n,
    input  logic brdy_n,
    input  logic surrender,
    input  logic mark_in,
    input  logic read_in,
    output logic cache_n_o,
    output logic drive_o,
    output logic first_rdy_o,
    output logic held_o,
    output logic mark_q_o,
    output logic read_q_o
);
    phase_e st, st_nx;
    logic   capture;
    logic   mark_q, read_q;
    logic   ready;

    assign ready = !rdy_n || !brdy_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            mark_q <= 1'b0;
            read_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (capture) begin
                mark_q <= mark_in;
                read_q <= read_in;
            end
        end
    end

    always_comb begin
        st_nx   = st;
        capture = 1'b0;
        unique case (st)
            ST_IDLE, ST_FLOAT: begin
                if (surrender) begin
                    st_nx = ST_FLOAT;
                end else if (!ads_n) begin
                    st_nx   = ST_HELD;
                    capture = 1'b1;
                end else begin
                    st_nx = ST_IDLE;
                end
            end
            ST_HELD: begin
                if (surrender)  st_nx = ST_FLOAT;
                else if (ready) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        drive_o     = !surrender;
        cache_n_o   = 1'b1;
        first_rdy_o = 1'b0;
        held_o      = 1'b0;
        unique case (st)
            ST_IDLE, ST_FLOAT: begin
                if (!surrender && !ads_n) cache_n_o = !mark_in;
            end
            ST_HELD: begin
                held_o      = 1'b1;
                cache_n_o   = !mark_q;
                first_rdy_o = ready && !surrender;
            end
            default: cache_n_o = 1'b1;
        endcase
    end

    assign mark_q_o = mark_q;
    assign read_q_o = read_q;
endmodule

// File: rtl/cattr_fill.sv
module cattr_fill (
    input  logic first_rdy,
    input  logic held_read,
    input  logic held_mark,
    input  logic ken_n,
    output logic fill
);
    always_comb begin
        fill = first_rdy && held_read && held_mark && !ken_n;
    end
endmodule

// File: rtl/cache_attr_drv.sv
module cache_attr_drv
    import cattr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ads_n,
    input  logic [CYC_W-1:0] cyc_kind,
    input  logic             page_cacheable,
    input  logic             rdy_n,
    input  logic             brdy_n,
    input  logic             hlda,
    input  logic             boff_n,
    input  logic             ken_n,
    output logic             cache_n,
    output logic             cache_oe,
    output logic             line_fill
);
    logic surrender, mark_now, read_now;
    logic first_rdy, ph_held, mark_q, read_q;

    assign surrender = hlda || !boff_n;

    cattr_decode dec_i (
        .kind      (cyc_kind),
        .cacheable (page_cacheable),
        .mark      (mark_now),
        .is_read   (read_now)
    );

    cattr_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ads_n       (ads_n),
        .rdy_n       (rdy_n),
        .brdy_n      (brdy_n),
        .surrender   (surrender),
        .mark_in     (mark_now),
        .read_in     (read_now),
        .cache_n_o   (cache_n),
        .drive_o     (cache_oe),
        .first_rdy_o (first_rdy),
        .held_o      (ph_held),
        .mark_q_o    (mark_q),
        .read_q_o    (read_q)
    );

    cattr_fill fill_i (
        .first_rdy (first_rdy),
        .held_read (read_q),
        .held_mark (mark_q),
        .ken_n     (ken_n),
        .fill      (line_fill)
    );
endmodule

// File: rtl/cache_attr_chk.sv
module cache_attr_chk
    import cattr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ads_n,
    input logic [CYC_W-1:0] cyc_kind,
    input logic             page_cacheable,
    input logic             rdy_n,
    input logic             brdy_n,
    input logic             hlda,
    input logic             boff_n,
    input logic             ken_n,
    input logic             cache_n,
    input logic             cache_oe,
    input logic             line_fill,
    input logic             held
);
    logic strobe;
    assign strobe = !held && !ads_n && cache_oe;

    AST_FLOAT_ON_SURRENDER: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda || !boff_n) |-> (!cache_oe && !line_fill)); // R8
    AST_LOCKED_UNMARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cyc_kind == CYC_LOCK_RD) |-> cache_n); // R3
    AST_WRITE_UNMARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cyc_kind >= CYC_WRITE) |-> cache_n); // R4
    AST_WB_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (cyc_kind == CYC_WB_REPL || cyc_kind == CYC_WB_SNOOP)) |-> !cache_n); // R5
    AST_READ_FOLLOWS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cyc_kind == CYC_READ) |-> (cache_n == !page_cacheable)); // R6
    AST_DROP_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (held && cache_oe && (!rdy_n || !brdy_n)) |=> (cache_n || !ads_n)); // R2
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held) && cache_oe && $past(cache_oe)) |-> $stable(cache_n)); // R7
    AST_FILL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        line_fill |-> (!cache_n && !ken_n && cache_oe && held)); // R10
    AST_FILL_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        line_fill |-> (!rdy_n || !brdy_n)); // R10
endmodule

bind cache_attr_drv cache_attr_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ads_n          (ads_n),
    .cyc_kind       (cyc_kind),
    .page_cacheable (page_cacheable),
    .rdy_n          (rdy_n),
    .brdy_n         (brdy_n),
    .hlda           (hlda),
    .boff_n         (boff_n),
    .ken_n          (ken_n),
    .cache_n        (cache_n),
    .cache_oe       (cache_oe),
    .line_fill      (line_fill),
    .held           (ph_held)
);

// File: tb/cache_attr_drv_tb_top.sv
module cache_attr_drv_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, ads_n, page_cacheable, rdy_n, brdy_n, hlda, boff_n, ken_n;
    logic [2:0] cyc_kind;
    logic cache_n, cache_oe, line_fill;
    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_attr_drv dut_i (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cyc_kind(cyc_kind),
        .page_cacheable(page_cacheable), .rdy_n(rdy_n), .brdy_n(brdy_n),
        .hlda(hlda), .boff_n(boff_n), .ken_n(ken_n),
        .cache_n(cache_n), .cache_oe(cache_oe), .line_fill(line_fill)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    function automatic logic exp_mark(input int k, input int ca);
        return (k == 0 && ca == 1) || k == 2 || k == 3;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ads_n = 1'b1; cyc_kind = 3'd0; page_cacheable = 1'b0;
        rdy_n = 1'b1; brdy_n = 1'b1; hlda = 1'b0; boff_n = 1'b1; ken_n = 1'b1;
        repeat (3) settle();
        chk("R1 cache_n in reset", cache_n, 1'b1);
        chk("R1 cache_oe in reset", cache_oe, 1'b1);
        chk("R1 line_fill in reset", line_fill, 1'b0);
        drive_edge(); rst_n = 1'b1;
        settle();
        chk("R1 cache_n after reset", cache_n, 1'b1);

        for (int k = 0; k < 8; k++)
          for (int ca = 0; ca < 2; ca++)
            for (int kn = 0; kn < 2; kn++)
              for (int w = 0; w < 3; w++)
                for (int rt = 0; rt < 2; rt++) begin
                    logic m;
                    m = exp_mark(k, ca);
                    drive_edge();
                    ads_n = 1'b0; cyc_kind = 3'(k); page_cacheable = 1'(ca);
                    settle();
                    if (k == 1)      chk("R3 locked read strobe", cache_n, 1'b1);
                    else if (k >= 4) chk("R4 write strobe", cache_n, 1'b1);
                    else if (k >= 2) chk("R5 write-back strobe", cache_n, 1'b0);
                    else             chk("R6 read strobe", cache_n, !m);
                    chk("R8 driven while owned", cache_oe, 1'b1);
                    for (int i = 0; i < w; i++) begin
                        drive_edge();
                        ads_n = 1'b1; cyc_kind = ~3'(k); page_cacheable = ~1'(ca);
                        settle();
                        chk("R7 held across wait", cache_n, !m);
                    end
                    drive_edge();
                    ads_n = 1'b1; ken_n = 1'(kn);
                    if (rt == 0) rdy_n = 1'b0; else brdy_n = 1'b0;
                    settle();
                    chk("R7 held at ready", cache_n, !m);
                    chk("R10 fill decision", line_fill, (k == 0 && ca == 1 && kn == 0));
                    drive_edge();
                    rdy_n = 1'b1; brdy_n = 1'b1; ken_n = 1'b1;
                    settle();
                    chk("R2 dropped after ready", cache_n, 1'b1);
                    chk("R10 no fill after ready", line_fill, 1'b0);
                    drive_edge();
                    settle();
                    chk("R2 stays high before strobe", cache_n, 1'b1);
                end

        for (int s = 0; s < 2; s++) begin
            drive_edge(); ads_n = 1'b0; cyc_kind = 3'd0; page_cacheable = 1'b1;
            settle(); chk("R6 cacheable read", cache_n, 1'b0);
            drive_edge(); ads_n = 1'b1;
            settle(); chk("R7 wait", cache_n, 1'b0);
            drive_edge();
            if (s == 0) hlda = 1'b1; else boff_n = 1'b0;
            rdy_n = 1'b0; ken_n = 1'b0;
            settle();
            chk("R8 float on surrender", cache_oe, 1'b0);
            chk("R8 no fill while floating", line_fill, 1'b0);
            drive_edge(); rdy_n = 1'b1; ken_n = 1'b1; ads_n = 1'b0; cyc_kind = 3'd2;
            settle(); chk("R8 still floating", cache_oe, 1'b0);
            drive_edge(); hlda = 1'b0; boff_n = 1'b1; ads_n = 1'b1;
            settle();
            chk("R9 driven after release", cache_oe, 1'b1);
            chk("R9 no stale mark", cache_n, 1'b1);
            drive_edge(); ads_n = 1'b0; cyc_kind = 3'd3; page_cacheable = 1'b0;
            settle(); chk("R9 recomputed on restart", cache_n, 1'b0);
            drive_edge(); ads_n = 1'b1; brdy_n = 1'b0; ken_n = 1'b0;
            settle(); chk("R10 no fill for write-back", line_fill, 1'b0);
            drive_edge(); brdy_n = 1'b1; ken_n = 1'b1;
            settle(); chk("R2 drop after write-back", cache_n, 1'b1);
        end

        drive_edge(); hlda = 1'b1; ads_n = 1'b0; cyc_kind = 3'd0; page_cacheable = 1'b1;
        settle(); chk("R8 float in strobe cycle", cache_oe, 1'b0);
        drive_edge(); hlda = 1'b0; ads_n = 1'b1;
        settle(); chk("R9 strobe under hold ignored", cache_n, 1'b1);
        drive_edge(); rdy_n = 1'b0; ken_n = 1'b0;
        settle(); chk("R9 no fill from ignored strobe", line_fill, 1'b0);
        drive_edge(); rdy_n = 1'b1; ken_n = 1'b1;
        settle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule